// File: doc/BRIEF.md
# Half-Step Fine-Tuned PWM Generator

This block produces one pulse-width-modulated output. The output period and the duty time are both counted in ticks of a PWM clock. That clock is the block clock divided by 1, 2, 4 or 8. A one-bit fine-tune adds half a tick to the duty time on average. It does this by making alternate periods one tick longer in their active part. A polarity bit chooses whether the duty portion is driven high or low. Two corner cases have fixed outputs: a zero period gives a constant inactive level, and a duty that is not less than the period gives a constant active level.

Software writes all settings as 4-bit nibbles through a narrow write port. Period, duty and fine-tune writes first go to staging registers. The generator takes them into use only at the next period boundary, and only once the high nibble of that value has been written. This lets the duty or period be changed mid-stream without a torn waveform. The enable bit also drives a select output, which hands the shared pin to the generator or returns it to general I/O.

Top module: `pwm_halfstep`

## Requirements
- R1: Write addresses are 0 control (bit0 enable, bits 2:1 clock-divide code, bit3 polarity), 1 fine-tune (bit0), 2 period low nibble, 3 period high nibble, 4 duty low nibble, 5 duty high nibble; other addresses are ignored. After reset, enable, divide code and polarity are 0, the period and duty in use are 0, and both outputs are 0.
- R2: `pwm_sel` equals the enable bit. While disabled, `pwm_out` sits at the polarity bit's value.
- R3: With divide code n, a PWM tick occurs on every 2^n-th clock, counted from the first enabled clock.
- R4: The period counter starts at 1, advances once per tick, and returns to 1 on the tick in which it has reached the period value in use. One output period is therefore P ticks.
- R5: The output is active while the count is at most the duty value D. Active means high for polarity 0 and low for polarity 1.
- R6: With fine-tune set, periods alternate between D and D+1 active ticks, starting with D after enable. Over two periods the output is active for 2D+1 ticks.
- R7: A period value of 0 gives a constant inactive level: low for polarity 0, high for polarity 1.
- R8: A period value that is at most the duty value gives a constant active level.
- R9: Writes to staged nibbles change nothing at the output until the high nibble of the same value has been written. The staged period, or the staged duty with its fine-tune, is then adopted at the next period boundary. While the block is disabled, it is adopted on the next clock.
- R10: On the first enabled clock the count is 1, the prescaler is cleared and the fine-tune phase is the short period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 4 | Register write nibble |
| pwm_out | output | 1 | PWM waveform |
| pwm_sel | output | 1 | 1 routes the PWM to the shared pin, 0 leaves it as general I/O |

## Verification
Both outputs are decoded from registers alone, so every effect appears right after the rising edge on which its cause is taken. A control write shows at the outputs after the edge that samples the strobe. A high-nibble write while running shows after the first boundary edge that follows it. A boundary edge is a tick edge at which the count has reached the period. The bench keeps its own per-clock model of ticks, counts, staging and phase, advanced on each rising edge. It compares both outputs with that model on every falling edge, half a cycle after the edge that set the expected value. Duty-averaging windows of whole periods are counted separately.

// File: rtl/pwm_hs_pkg.sv
package pwm_hs_pkg;
   // register address plan (nibble registers)
   localparam int ADR_CTRL     = 0;
   localparam int ADR_FINE     = 1;
   localparam int ADR_PER_BASE = 2;

   function automatic int duty_base(input int nibs);
      return ADR_PER_BASE + nibs;
   endfunction

   function automatic int last_addr(input int nibs);
      return ADR_PER_BASE + 2 * nibs - 1;
   endfunction
endpackage

// File: rtl/pwm_hs_regs.sv
module pwm_hs_regs
   import pwm_hs_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int DIV_W  = 2,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [3:0]        wr_data,
   input  logic              commit,
   output logic              en,
   output logic [DIV_W-1:0]  div,
   output logic              pol,
   output logic [CNT_W-1:0]  per_stg,
   output logic [CNT_W-1:0]  duty_stg,
   output logic              fine_stg,
   output logic              per_pend,
   output logic              duty_pend
);
   localparam int NIB    = CNT_W / 4;
   localparam int D_BASE = duty_base(NIB);

   logic per_hi_wr, duty_hi_wr;

   assign per_hi_wr  = wr_en && (wr_addr == ADDR_W'(ADR_PER_BASE + NIB - 1));
   assign duty_hi_wr = wr_en && (wr_addr == ADDR_W'(D_BASE + NIB - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en  <= 1'b0;
         div <= '0;
         pol <= 1'b0;
      end else if (wr_en && wr_addr == ADDR_W'(ADR_CTRL)) begin
         en  <= wr_data[0];
         div <= wr_data[DIV_W:1];
         pol <= wr_data[DIV_W+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_stg  <= '0;
         duty_stg <= '0;
         fine_stg <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADR_FINE))
            fine_stg <= wr_data[0];
         for (int i = 0; i < NIB; i++) begin
            if (wr_addr == ADDR_W'(ADR_PER_BASE + i))
               per_stg[4*i +: 4] <= wr_data;
            if (wr_addr == ADDR_W'(D_BASE + i))
               duty_stg[4*i +: 4] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_pend  <= 1'b0;
         duty_pend <= 1'b0;
      end else begin
         per_pend  <= per_hi_wr  | (per_pend  & ~commit);
         duty_pend <= duty_hi_wr | (duty_pend & ~commit);
      end
   end

   AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !per_hi_wr && !duty_hi_wr) |=> (!per_pend && !duty_pend)); // R9
   AST_HI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      per_hi_wr |=> per_pend); // R9
endmodule

// File: rtl/pwm_hs_prescale.sv
module pwm_hs_prescale #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PRE_W = (1 << DIV_W) - 1;

   logic [PRE_W-1:0] pre;
   logic [PRE_W-1:0] mask;

   always_comb mask = ~({PRE_W{1'b1}} << div);
   assign tick = run && ((pre & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre <= '0;
      else if (!run) pre <= '0;
      else           pre <= pre + 1'b1;
   end

   AST_TICK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (run && div == '0) |-> tick); // R3
   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> (!tick || !$stable(div))); // R3
endmodule

// File: rtl/pwm_hs_core.sv
module pwm_hs_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             pol,
   input  logic             tick,
   input  logic [CNT_W-1:0] per_stg,
   input  logic [CNT_W-1:0] duty_stg,
   input  logic             fine_stg,
   input  logic             per_pend,
   input  logic             duty_pend,
   output logic             commit,
   output logic             pwm_out
);
   logic [CNT_W-1:0] cnt, per_act, duty_act;
   logic             fine_act, phase, boundary, active;
   logic [CNT_W:0]   duty_eff;

   assign boundary = tick && (cnt >= per_act);
   assign commit   = !en || boundary;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= CNT_W'(1);
         phase <= 1'b0;
      end else if (!en) begin
         cnt   <= CNT_W'(1);
         phase <= 1'b0;
      end else if (boundary) begin
         cnt   <= CNT_W'(1);
         phase <= ~phase;
      end else if (tick) begin
         cnt   <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_act  <= '0;
         duty_act <= '0;
         fine_act <= 1'b0;
      end else if (commit) begin
         if (per_pend) per_act <= per_stg;
         if (duty_pend) begin
            duty_act <= duty_stg;
            fine_act <= fine_stg;
         end
      end
   end

   assign duty_eff = {1'b0, duty_act} + (CNT_W+1)'(fine_act & phase);
   assign active   = (per_act != '0) &&
                     ((per_act <= duty_act) || ({1'b0, cnt} <= duty_eff));
   assign pwm_out  = en ? (active ^ pol) : pol;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (en && per_act != '0) |-> (cnt != '0 && cnt <= per_act)); // R4
   AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(per_act)); // R9
   AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(duty_act) && $stable(fine_act))); // R9
   AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == CNT_W'(1) && !phase)); // R10
endmodule

// File: rtl/pwm_halfstep.sv
module pwm_halfstep
   import pwm_hs_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int DIV_W  = 2,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [3:0]        wr_data,
   output logic              pwm_out,
   output logic              pwm_sel
);
   localparam int NIB = CNT_W / 4;

   generate
      if (CNT_W < 4 || (CNT_W % 4) != 0) begin : g_chk_w
         $error("CNT_W must be a positive multiple of 4");
      end
      if (DIV_W < 1 || DIV_W > 2) begin : g_chk_div
         $error("DIV_W must be 1 or 2 to fit the control nibble");
      end
      if (last_addr(NIB) >= (1 << ADDR_W)) begin : g_chk_addr
         $error("ADDR_W too narrow for the register plan");
      end
   endgenerate

   logic             en, pol, tick, commit, fine_stg, per_pend, duty_pend;
   logic [DIV_W-1:0] div;
   logic [CNT_W-1:0] per_stg, duty_stg;

   pwm_hs_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .commit(commit), .en(en), .div(div), .pol(pol),
      .per_stg(per_stg), .duty_stg(duty_stg), .fine_stg(fine_stg),
      .per_pend(per_pend), .duty_pend(duty_pend)
   );

   pwm_hs_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(en), .div(div), .tick(tick)
   );

   pwm_hs_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en), .pol(pol), .tick(tick),
      .per_stg(per_stg), .duty_stg(duty_stg), .fine_stg(fine_stg),
      .per_pend(per_pend), .duty_pend(duty_pend), .commit(commit),
      .pwm_out(pwm_out)
   );

   assign pwm_sel = en;

   AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_sel |-> (pwm_out == pol)); // R2
endmodule

// File: tb/sim_pwm_halfstep.sv
`timescale 1ns/1ps
module sim_pwm_halfstep;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [3:0] wr_data = '0;
   logic       pwm_out, pwm_sel;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int m_en, m_div, m_pol, stg_per, stg_duty, stg_fine, pend_p, pend_d;
   int act_per, act_duty, act_fine, cnt, pre, phase;

   always #2.5 clk = ~clk;

   pwm_halfstep u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .pwm_out(pwm_out), .pwm_sel(pwm_sel)
   );

   function automatic int exp_out();
      int a;
      if (m_en == 0) return m_pol;
      if (act_per == 0) a = 0;
      else if (act_per <= act_duty) a = 1;
      else a = (cnt <= act_duty + (act_fine & phase)) ? 1 : 0;
      return a ? (1 - m_pol) : m_pol;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_div = 0; m_pol = 0; stg_per = 0; stg_duty = 0; stg_fine = 0;
         pend_p = 0; pend_d = 0; act_per = 0; act_duty = 0; act_fine = 0;
         cnt = 1; pre = 0; phase = 0;
      end else begin
         int mask, tk, bnd;
         mask = (1 << m_div) - 1;
         tk   = (m_en != 0) && ((pre & mask) == mask);
         bnd  = tk && (cnt >= act_per);
         if (m_en == 0 || bnd) begin
            if (pend_p != 0) begin act_per = stg_per; pend_p = 0; end
            if (pend_d != 0) begin act_duty = stg_duty; act_fine = stg_fine; pend_d = 0; end
         end
         if (m_en == 0) begin
            pre = 0; cnt = 1; phase = 0;
         end else begin
            pre = (pre + 1) & 7;
            if (bnd) begin cnt = 1; phase = 1 - phase; end
            else if (tk) cnt = cnt + 1;
         end
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_en = wr_data[0]; m_div = wr_data[2:1]; m_pol = wr_data[3]; end
               3'd1: stg_fine = wr_data[0];
               3'd2: stg_per  = (stg_per & 8'hF0) | wr_data;
               3'd3: begin stg_per = (stg_per & 8'h0F) | (wr_data << 4); pend_p = 1; end
               3'd4: stg_duty = (stg_duty & 8'hF0) | wr_data;
               3'd5: begin stg_duty = (stg_duty & 8'h0F) | (wr_data << 4); pend_d = 1; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input int act, input int exp, input string req, input string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(pwm_out), exp_out(), tag, "pwm_out");
         chk(int'(pwm_sel), m_en, "R2", "pwm_sel");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 4'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_active(input int n, output int hi);
      hi = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pwm_out) hi++;
      end
   endtask

   initial begin
      int h;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(pwm_out), 0, "R1", "reset pwm_out");
      chk(int'(pwm_sel), 0, "R1", "reset pwm_sel");

      // period 13, duty 6, no fine, divide by 1, active high
      tag = "R4";
      wr(2, 4'hD); wr(3, 0); wr(1, 0); wr(4, 6); wr(5, 0);
      wr(6, 4'hF); wr(7, 4'hF);            // unused addresses, R1
      wr(0, 4'b0001);
      chk(int'(pwm_out), 1, "R10", "first enabled clock active");
      idle(30);
      tag = "R5";
      count_active(26, h);
      chk(h, 12, "R5", "active ticks over two periods");

      // fine-tune half step
      tag = "R6";
      wr(1, 1); wr(5, 0);
      idle(30);
      count_active(26, h);
      chk(h, 13, "R6", "active ticks with fine-tune");

      // inverted polarity
      tag = "R5";
      wr(0, 4'b1001);
      idle(10);
      count_active(26, h);
      chk(26 - h, 13, "R5", "low ticks with polarity 1");

      // divide codes
      tag = "R3";
      wr(0, 4'b0011); idle(80);
      wr(0, 4'b0101); idle(130);
      wr(0, 4'b0111); idle(240);

      // staging: low nibble only, then high nibble
      tag = "R9";
      wr(0, 4'b0001);
      wr(2, 4'h5);
      idle(40);
      count_active(26, h);
      chk(h, 13, "R9", "low nibble alone keeps old period");
      wr(3, 0);
      idle(20);
      wr(4, 2); wr(1, 0);
      idle(15);
      wr(5, 0);
      idle(20);
      count_active(10, h);
      chk(h, 4, "R9", "new period 5 duty 2 in use");

      // zero period
      tag = "R7";
      wr(2, 0); wr(3, 0);
      idle(20);
      chk(int'(pwm_out), 0, "R7", "zero period pol0");
      wr(0, 4'b1001);
      idle(10);
      chk(int'(pwm_out), 1, "R7", "zero period pol1");

      // duty not less than period
      tag = "R8";
      wr(2, 4); wr(3, 0); wr(4, 9); wr(5, 0);
      idle(20);
      chk(int'(pwm_out), 0, "R8", "full active pol1");
      wr(0, 4'b0001);
      idle(10);
      chk(int'(pwm_out), 1, "R8", "full active pol0");
      wr(4, 4); wr(5, 0);
      idle(20);
      chk(int'(pwm_out), 1, "R8", "duty equal to period");

      // disable with polarity 1
      tag = "R2";
      wr(0, 4'b1000);
      chk(int'(pwm_sel), 0, "R2", "disabled select");
      chk(int'(pwm_out), 1, "R2", "disabled level");
      wr(2, 3); wr(3, 0); wr(4, 1); wr(5, 0); wr(1, 1);
      idle(3);

      // restart
      tag = "R10";
      wr(0, 4'b0011);
      chk(int'(pwm_out), 1, "R10", "restart count at 1");
      idle(60);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule